// File: doc/BRIEF.md
# Supply-Monitor Qualification Filter and Status Register

The block sits between an analog supply monitor and the bus. The monitor has two pairs of comparators, one pair for a tight tolerance and one for a loose tolerance. Each pair reports "supply below trip level" and "supply above recovery level". The block passes all four comparator outputs through a two-flop synchronizer. A control bit picks which pair is used. A short dip below the trip level is rejected by a consecutive-cycle counter. Hysteresis applies between the trip and recovery levels. The qualified result is a low-voltage flag.

A byte-wide register gives bus access. It holds the read-only flag and the writable tolerance select. When the tolerance changes while the newly chosen trip comparator is already asserted, the block issues a one-cycle reset request to the system reset controller. In wait mode the monitor keeps running only when the power-enable configuration input is set. Otherwise the filter is idle: its counter is cleared and the flag is frozen. The block has no interrupt output.

Top module: `supmon_top`

## Requirements
- R1: While the selected trip input has been high for fewer than 32 consecutive clocks, `low_flag_o` stays 0. The run count restarts whenever that input goes low.
- R2: Once the selected trip input has been high for more than 40 consecutive clocks, measured at the pins, `low_flag_o` is 1. It stays 1 while the input remains high.
- R3: While the selected recovery input is high and the monitor is active, `low_flag_o` goes to 0 within 4 clocks, whatever the duration.
- R4: While neither selected input is high, `low_flag_o` keeps its previous value.
- R5: The register read value `rd_data_o` has the flag in bit 7 (read-only) and the select in bit 5 (read/write). All other bits read 0 and ignore writes. Reset clears the register, the flag and `reset_req_o`.
- R6: A select of 1 uses the tight pair (`trip_tight_i`, `rec_tight_i`). A select of 0 uses the loose pair (`trip_loose_i`, `rec_loose_i`). The unselected pair has no effect on the flag.
- R7: When `wait_i`=1 and `pwr_en_i`=0, the monitor is idle. The flag holds and no qualification happens. When `pwr_en_i`=1, the monitor runs normally in wait mode.
- R8: A write that changes the select, while the newly selected trip input (after synchronization) is high, makes `reset_req_o` high for exactly the one cycle after the write edge. Any other write produces no pulse.
- R9: Every change of the select restarts the qualification count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trip_tight_i | input | 1 | Tight-tolerance below-trip comparator |
| rec_tight_i | input | 1 | Tight-tolerance above-recovery comparator |
| trip_loose_i | input | 1 | Loose-tolerance below-trip comparator |
| rec_loose_i | input | 1 | Loose-tolerance above-recovery comparator |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| pwr_en_i | input | 1 | Keep monitor running in wait mode |
| wait_i | input | 1 | Wait mode indication |
| rd_data_o | output | 8 | Register read value |
| low_flag_o | output | 1 | Qualified low-voltage flag |
| reset_req_o | output | 1 | One-cycle reset request |

## Verification
The bench targets the following corner cases:
- Dips of 30 cycles separated by a short recovery pulse. A counter that did not restart would add the two dips together and raise the flag falsely.
- The hysteresis band. A design without hold would drop the flag as soon as the trip comparator releases.
- Activity on the unselected comparator pair. A wrong select mux would trip on it.
- A select change mid-run. Without the counter restart, 30+30 cycles of low supply would qualify.
- Wait mode without power enable. A design that ignored it would set or clear the flag.
- Select writes with and without the new trip input asserted. A missing or spurious reset-request pulse shows up at the port.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int CNT_W    = 6;
  localparam int THRESH   = 36;
  localparam int SYNC_N   = 2;
  localparam int FLAG_BIT = 7;
  localparam int SEL_BIT  = 5;
  localparam logic [7:0] WR_MASK  = 8'(1 << SEL_BIT);
  localparam logic [7:0] RSV_MASK = ~(8'(1 << SEL_BIT) | 8'(1 << FLAG_BIT));

  typedef struct packed {
    logic trip_t;
    logic rec_t;
    logic trip_l;
    logic rec_l;
  } cmp_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int W = 4,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [N];

  for (genvar i = 0; i < N; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = stg_q[N-1];
endmodule

// File: rtl/supmon_filter.sv
module supmon_filter
  import supmon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmp_t cmp_i,
  input  logic sel_i,
  input  logic restart_i,
  input  logic active_i,
  output logic flag_o
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

  logic below, above;
  logic [CNT_W-1:0] cnt_q;
  logic flag_q;

  assign below = sel_i ? cmp_i.trip_t : cmp_i.trip_l;
  assign above = sel_i ? cmp_i.rec_t  : cmp_i.rec_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!active_i || restart_i || !below) cnt_q <= '0;
    else if (cnt_q != THR) cnt_q <= cnt_q + 1'b1;
  end

  // recovery wins over trip; band holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (active_i) begin
      if (above) flag_q <= 1'b0;
      else if (cnt_q == THR) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  always_comb AST_CNT_SAT: assert (!rst_ni || cnt_q <= THR); // R2

  AST_RISE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(below) && $past(cnt_q) >= CNT_W'(32)); // R1
  AST_ABOVE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && above) |=> !flag_o); // R3
  AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !above && !below) |=> $stable(flag_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(flag_o)); // R7
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  cmp_t       cmp_i,
  input  logic       flag_i,
  output logic       sel_o,
  output logic       sel_chg_o,
  output logic [7:0] rd_data_o,
  output logic       reset_req_o
);
  logic [7:0] ctl_q;
  logic       req_q;
  logic       new_sel, new_below;

  assign new_sel   = wr_data_i[SEL_BIT];
  assign sel_o     = ctl_q[SEL_BIT];
  assign sel_chg_o = wr_en_i && (new_sel != sel_o);
  assign new_below = new_sel ? cmp_i.trip_t : cmp_i.trip_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (wr_en_i) ctl_q <= wr_data_i & WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else req_q <= sel_chg_o && new_below;
  end

  assign rd_data_o   = ctl_q | (8'(flag_i) << FLAG_BIT);
  assign reset_req_o = req_q;

  always_comb AST_RSV_ZERO: assert (!rst_ni || (rd_data_o & RSV_MASK) == 8'h00); // R5

  AST_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[SEL_BIT] == $past(wr_data_i[SEL_BIT])); // R5
  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(wr_en_i)); // R8
endmodule

// File: rtl/supmon_top.sv
module supmon_top
  import supmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trip_tight_i,
  input  logic       rec_tight_i,
  input  logic       trip_loose_i,
  input  logic       rec_loose_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       pwr_en_i,
  input  logic       wait_i,
  output logic [7:0] rd_data_o,
  output logic       low_flag_o,
  output logic       reset_req_o
);
  cmp_t cmp_raw, cmp_s;
  logic sel, sel_chg, active, flag;

  assign cmp_raw = '{trip_t: trip_tight_i, rec_t: rec_tight_i,
                     trip_l: trip_loose_i, rec_l: rec_loose_i};
  assign active  = !wait_i || pwr_en_i;

  supmon_sync #(.W($bits(cmp_t)), .N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i(cmp_raw), .q_o(cmp_s)
  );

  supmon_filter u_filt (
    .clk_i, .rst_ni, .cmp_i(cmp_s), .sel_i(sel), .restart_i(sel_chg),
    .active_i(active), .flag_o(flag)
  );

  supmon_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .cmp_i(cmp_s), .flag_i(flag),
    .sel_o(sel), .sel_chg_o(sel_chg), .rd_data_o, .reset_req_o
  );

  assign low_flag_o = flag;
endmodule

// File: tb/tb_supmon_top.sv
module tb_supmon_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tt = 0, rt = 0, tl = 0, rl = 0;
  logic wr_en = 0, pwr_en = 0, wt = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic flag, req;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  supmon_top dut (
    .clk_i(clk), .rst_ni, .trip_tight_i(tt), .rec_tight_i(rt),
    .trip_loose_i(tl), .rec_loose_i(rl), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .pwr_en_i(pwr_en), .wait_i(wt), .rd_data_o(rd_data),
    .low_flag_o(flag), .reset_req_o(req)
  );

  // {sel, tt, rt, tl, rl, cycles[7:0], exp_flag}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 4'b0000, 8'd10, 1'b0},  // R4 idle band
    {1'b0, 4'b0010, 8'd30, 1'b0},  // R1 short dip
    {1'b0, 4'b0001, 8'd5,  1'b0},  // R1 break run
    {1'b0, 4'b0010, 8'd30, 1'b0},  // R1 restart
    {1'b0, 4'b0010, 8'd45, 1'b1},  // R2 sustained
    {1'b0, 4'b0000, 8'd20, 1'b1},  // R4 hold in band
    {1'b0, 4'b0001, 8'd4,  1'b0},  // R3 recovery
    {1'b0, 4'b1000, 8'd50, 1'b0},  // R6 unselected trip
    {1'b1, 4'b1000, 8'd45, 1'b1},  // R6 tight trip
    {1'b1, 4'b0001, 8'd10, 1'b1},  // R6 unselected recovery
    {1'b1, 4'b0100, 8'd4,  1'b0}   // R3 tight recovery
  };

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_data = d; wr_en = 1;
    cyc(1);
    wr_en = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hang exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R5 reset rd", rd_data, 8'h00);
    chk("R5 reset flag", {7'b0, flag}, 8'h00);
    chk("R5 reset req", {7'b0, req}, 8'h00);
    rst_ni = 1;
    cyc(2);

    // R5 register layout
    wr(8'hFF);
    chk("R5 wr ff", rd_data, 8'h20);
    chk("R8 no pulse", {7'b0, req}, 8'h00);
    wr(8'h00);
    chk("R5 wr 00", rd_data, 8'h00);

    // R9 select change restarts count
    tl = 1; tt = 1;
    cyc(32);
    wr(8'h20);
    chk("R8 pulse", {7'b0, req}, 8'h01);
    cyc(1);
    chk("R8 single", {7'b0, req}, 8'h00);
    cyc(28);
    chk("R9 restarted", {7'b0, flag}, 8'h00);
    cyc(20);
    chk("R9 later set", {7'b0, flag}, 8'h01);
    // R8 no pulse when new trip low
    tl = 0;
    cyc(4);
    wr(8'h00);
    cyc(1);
    chk("R8 no pulse low", {7'b0, req}, 8'h00);
    tt = 0; rl = 1;
    cyc(5);
    chk("R3 clear", {7'b0, flag}, 8'h00);
    rl = 0;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      if (rd_data[5] != v[13]) wr({2'b0, v[13], 5'b0});
      {tt, rt, tl, rl} = v[12:9];
      cyc(int'(v[8:1]));
      chk($sformatf("R1-6 vec %0d", i), {7'b0, flag}, {7'b0, v[0]});
      chk($sformatf("R5 vec rd %0d", i), rd_data, {v[0], 1'b0, v[13], 5'b0});
    end

    // R7 wait without power enable
    {tt, rt, tl, rl} = 4'b1000;
    cyc(45);
    chk("R7 pre set", {7'b0, flag}, 8'h01);
    wt = 1; pwr_en = 0;
    {tt, rt, tl, rl} = 4'b0100;
    cyc(10);
    chk("R7 idle hold 1", {7'b0, flag}, 8'h01);
    wt = 0;
    cyc(2);
    chk("R7 resume clear", {7'b0, flag}, 8'h00);
    wt = 1;
    {tt, rt, tl, rl} = 4'b1000;
    cyc(60);
    chk("R7 idle no trip", {7'b0, flag}, 8'h00);
    pwr_en = 1;
    cyc(45);
    chk("R7 pwr_en runs", {7'b0, flag}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule